// File: doc/BRIEF.md
# Three-Axis Single and Double Tap Detector

This block watches a stream of three-axis acceleration samples and picks out short spikes, called taps. A tap is a pulse that climbs above a per-axis threshold and falls back below it before a programmable time limit runs out. The detector can then wait through a quiet latency period and open a window for a second tap. A second tap found in that window is reported as a double tap. Each axis runs its own state machine. All timing counts use a shared tick that is divided down from the block clock.

Results go into a seven-bit source vector with one single-tap flag and one double-tap flag per axis, plus an active flag. The interrupt line follows the active flag. In latched mode the flags accumulate and stay set until a read strobe clears them. In pass-through mode each flag is high for exactly one cycle.

Each axis machine has six states:

- **IDLE**: waits for a rising crossing (IDLE→HIT1).
- **HIT1**: times the first pulse.
  - A fall before expiry is a valid tap. The machine goes HIT1→QUIET when double taps are enabled, and HIT1→IDLE otherwise.
  - Expiry gives HIT1→HOLD.
- **QUIET**: ignores all crossings for the latency period (QUIET→WIN).
- **WIN**: waits for a second rise.
  - A rise gives WIN→HIT2.
  - Expiry gives WIN→IDLE.
- **HIT2**: times the second pulse.
  - A fall before expiry reports a double tap (HIT2→IDLE).
  - Expiry gives HIT2→HOLD.
- **HOLD**: waits for the signal to drop below threshold (HOLD→IDLE).

From any state, a disabled axis forces a return to IDLE.

Top module: `tap_detector`

## Requirements
- R1: After reset `tap_src` is 0 and `tap_irq` is 0.
- R2: A sample counts as above threshold when the magnitude of its two's-complement value is strictly greater than the threshold code shifted left by FRAC (the LSB is 0.5 g / 2^FRAC). A threshold code of 0 disables the axis and forces its machine to IDLE.
- R3: A rise followed by a fall before the time limit expires is a valid tap. When single taps are enabled for that axis, the single flag is set: x at bit 0, y at bit 2, z at bit 4.
- R4: A pulse still above threshold when the time limit expires produces no event. The axis re-arms only after a sample below threshold.
- R5: When single taps are disabled for an axis, no single flag is ever raised for it.
- R6: Crossings during the latency period that follows a first tap produce no event.
- R7: A second valid tap that rises inside the window sets the double flag: x at bit 1, y at bit 3, z at bit 5. The single and double flags of one axis never fire in the same cycle.
- R8: When the window expires with no second rise, the axis returns to IDLE, and a later tap is again a first (single) tap.
- R9: With `cfg_latch` low, `tap_src[5:0]` shows the events of the previous cycle only.
- R10: With `cfg_latch` high, the flags hold until `src_rd`, which clears them on the next edge. An event in the same cycle as `src_rd` sets its flag anyway.
- R11: `tap_src[6]` is the OR of bits 5:0. `tap_irq` equals `tap_src[6]` and rises only after an event.
- R12: The tick fires once every TICK_CYCLES clocks.
  - The time limit expires on the tick at which the pulse counter equals `time_limit`, so a limit of 0 expires on the first tick.
  - Latency ends on the tick at which the counter equals `latency`.
  - The window ends on the tick at which the counter equals `window`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe for all three axes |
| smp_x | input | SW | X sample, two's complement |
| smp_y | input | SW | Y sample, two's complement |
| smp_z | input | SW | Z sample, two's complement |
| thr_x | input | 4 | X threshold code, 0.5 g per step, 0 disables the axis |
| thr_y | input | 4 | Y threshold code |
| thr_z | input | 4 | Z threshold code |
| time_limit | input | TW | Maximum pulse width in ticks |
| latency | input | TW | Quiet period after a first tap, in ticks |
| window | input | TW | Second-tap window, in ticks |
| cfg_single_en | input | 3 | Per-axis single-tap enable ({z,y,x}) |
| cfg_double_en | input | 3 | Per-axis double-tap enable ({z,y,x}) |
| cfg_latch | input | 1 | 1 = flags held until read |
| src_rd | input | 1 | Read strobe that clears latched flags |
| tap_src | output | 7 | {active, dz, sz, dy, sy, dx, sx} |
| tap_irq | output | 1 | Interrupt, equal to the active flag |

## Verification
The contested cycle is one where a read of the latched source vector meets a brand-new tap event on another axis. The read must wipe the old flag, and the new flag must survive. The bench first latches an x single tap. It then raises `src_rd` on the exact negative edge that presents the falling sample of a y tap, so that the clear and the set land on the same clock edge. It then requires the vector to hold only the y single flag and the active bit.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int NAX   = 3;
    localparam int SRC_W = 2 * NAX + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT1,
        ST_QUIET,
        ST_WIN,
        ST_HIT2,
        ST_HOLD
    } tap_state_e;
endpackage

// File: rtl/tap_tick_gen.sv
module tap_tick_gen #(
    parameter int TICK_CYCLES = 62500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
    parameter int SW   = 10,
    parameter int FRAC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp,
    input  logic [3:0]    thr,
    output logic          rise,
    output logic          fall
);
    logic [SW-1:0] mag;
    logic [SW-1:0] thr_s;
    logic          above;
    logic          prev_q;

    assign mag   = smp[SW-1] ? (~smp + 1'b1) : smp;
    assign thr_s = SW'(thr) << FRAC;
    assign above = (mag > thr_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (smp_valid)
            prev_q <= above;
    end

    assign rise = smp_valid && above && !prev_q;
    assign fall = smp_valid && !above;
endmodule

// File: rtl/tap_axis_fsm.sv
module tap_axis_fsm
    import tap_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          axis_on,
    input  logic          rise,
    input  logic          fall,
    input  logic          sgl_en,
    input  logic          dbl_en,
    input  logic [TW-1:0] tlim,
    input  logic [TW-1:0] lat,
    input  logic [TW-1:0] win,
    output tap_state_e    st_o,
    output logic          sgl_evt,
    output logic          dbl_evt
);
    tap_state_e    st_q, st_d;
    logic [TW-1:0] cnt_q;
    logic          cnt_clr, cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (cnt_clr)
                cnt_q <= '0;
            else if (cnt_inc)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!axis_on) begin
            st_d    = ST_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (rise) begin
                        st_d    = ST_HIT1;
                        cnt_clr = 1'b1;
                    end
                end
                ST_HIT1: begin
                    if (fall) begin
                        cnt_clr = 1'b1;
                        st_d    = dbl_en ? ST_QUIET : ST_IDLE;
                    end else if (tick) begin
                        if (cnt_q == tlim) st_d = ST_HOLD;
                        else               cnt_inc = 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (tick) begin
                        if (cnt_q == lat) begin
                            st_d    = ST_WIN;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_WIN: begin
                    if (rise) begin
                        st_d    = ST_HIT2;
                        cnt_clr = 1'b1;
                    end else if (tick) begin
                        if (cnt_q == win) st_d = ST_IDLE;
                        else              cnt_inc = 1'b1;
                    end
                end
                ST_HIT2: begin
                    if (fall) begin
                        st_d    = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else if (tick) begin
                        if (cnt_q == tlim) st_d = ST_HOLD;
                        else               cnt_inc = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (fall) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sgl_evt = axis_on && (st_q == ST_HIT1) && fall && sgl_en;
        dbl_evt = axis_on && (st_q == ST_HIT2) && fall && dbl_en;
    end

    assign st_o = st_q;
endmodule

// File: rtl/tap_src_reg.sv
module tap_src_reg #(
    parameter int NEV = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] evt,
    input  logic           latch,
    input  logic           rd,
    output logic [NEV:0]   src,
    output logic           irq
);
    logic [NEV-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (latch)
            flags_q <= (flags_q & ~{NEV{rd}}) | evt;
        else
            flags_q <= evt;
    end

    assign src = {|flags_q, flags_q};
    assign irq = |flags_q;
endmodule

// File: rtl/tap_detector.sv
module tap_detector
    import tap_pkg::*;
#(
    parameter int SW          = 10,
    parameter int FRAC        = 2,
    parameter int TW          = 8,
    parameter int TICK_CYCLES = 62500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SW-1:0]    smp_x,
    input  logic [SW-1:0]    smp_y,
    input  logic [SW-1:0]    smp_z,
    input  logic [3:0]       thr_x,
    input  logic [3:0]       thr_y,
    input  logic [3:0]       thr_z,
    input  logic [TW-1:0]    time_limit,
    input  logic [TW-1:0]    latency,
    input  logic [TW-1:0]    window,
    input  logic [NAX-1:0]   cfg_single_en,
    input  logic [NAX-1:0]   cfg_double_en,
    input  logic             cfg_latch,
    input  logic             src_rd,
    output logic [SRC_W-1:0] tap_src,
    output logic             tap_irq
);
    logic [SW-1:0]         smp_a [NAX];
    logic [3:0]            thr_a [NAX];
    logic                  tick;
    logic [NAX-1:0]        sgl_evt, dbl_evt;
    logic [2*NAX-1:0]      evt;
    tap_state_e [NAX-1:0]  ax_st;

    assign smp_a[0] = smp_x;
    assign smp_a[1] = smp_y;
    assign smp_a[2] = smp_z;
    assign thr_a[0] = thr_x;
    assign thr_a[1] = thr_y;
    assign thr_a[2] = thr_z;

    tap_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    generate
        for (genvar g = 0; g < NAX; g++) begin : g_axis
            logic rise, fall, axis_on;

            assign axis_on = (thr_a[g] != 4'd0) && (cfg_single_en[g] || cfg_double_en[g]);

            tap_axis_cmp #(.SW(SW), .FRAC(FRAC)) u_cmp (
                .clk      (clk),
                .rst_n    (rst_n),
                .smp_valid(smp_valid),
                .smp      (smp_a[g]),
                .thr      (thr_a[g]),
                .rise     (rise),
                .fall     (fall)
            );

            tap_axis_fsm #(.TW(TW)) u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .axis_on(axis_on),
                .rise   (rise),
                .fall   (fall),
                .sgl_en (cfg_single_en[g]),
                .dbl_en (cfg_double_en[g]),
                .tlim   (time_limit),
                .lat    (latency),
                .win    (window),
                .st_o   (ax_st[g]),
                .sgl_evt(sgl_evt[g]),
                .dbl_evt(dbl_evt[g])
            );

            assign evt[2*g]   = sgl_evt[g];
            assign evt[2*g+1] = dbl_evt[g];
        end
    endgenerate

    tap_src_reg #(.NEV(2*NAX)) u_src (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .latch(cfg_latch),
        .rd   (src_rd),
        .src  (tap_src),
        .irq  (tap_irq)
    );
endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk
    import tap_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_latch,
    input logic                 src_rd,
    input logic [NAX-1:0]       cfg_single_en,
    input logic [3:0]           thr_x,
    input logic [NAX-1:0]       sgl_evt,
    input logic [NAX-1:0]       dbl_evt,
    input logic [2*NAX-1:0]     evt,
    input tap_state_e [NAX-1:0] ax_st,
    input logic [SRC_W-1:0]     tap_src,
    input logic                 tap_irq
);
    // R10: latched flags only drop on a read
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_latch && !src_rd) |=> ((tap_src[5:0] & $past(tap_src[5:0])) == $past(tap_src[5:0])));

    // R9: pass-through mode mirrors last-cycle events
    p_pass_thru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_latch |=> (tap_src[5:0] == $past(evt)));

    // R11: interrupt rises only after an event
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tap_irq) |-> ($past(evt) != '0));

    // R7: single and double of one axis never together
    p_no_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sgl_evt & dbl_evt) == '0));

    // R5: disabled single taps stay silent
    p_single_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sgl_evt & ~cfg_single_en) == '0));

    // R2: zero threshold parks the axis in IDLE
    p_zero_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_x == 4'd0) |=> (ax_st[0] == ST_IDLE));
endmodule

bind tap_detector tap_detector_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_latch    (cfg_latch),
    .src_rd       (src_rd),
    .cfg_single_en(cfg_single_en),
    .thr_x        (thr_x),
    .sgl_evt      (sgl_evt),
    .dbl_evt      (dbl_evt),
    .evt          (evt),
    .ax_st        (ax_st),
    .tap_src      (tap_src),
    .tap_irq      (tap_irq)
);

// File: tb/tap_detector_bench.sv
`timescale 1ns/1ps
module tap_detector_bench;
    localparam int SW = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b1;
    logic [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [3:0]    thr_x = 4'd4, thr_y = 4'd4, thr_z = 4'd4;
    logic [TW-1:0] time_limit = 8'd6, latency = 8'd5, window = 8'd10;
    logic [2:0]    cfg_single_en = 3'b111, cfg_double_en = 3'b000;
    logic          cfg_latch = 1'b1;
    logic          src_rd = 1'b0;
    logic [6:0]    tap_src;
    logic          tap_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tap_detector #(.SW(SW), .FRAC(2), .TW(TW), .TICK_CYCLES(4)) u_tap_detector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
        .time_limit(time_limit), .latency(latency), .window(window),
        .cfg_single_en(cfg_single_en), .cfg_double_en(cfg_double_en),
        .cfg_latch(cfg_latch), .src_rd(src_rd),
        .tap_src(tap_src), .tap_irq(tap_irq)
    );

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input int ax, input int val);
        case (ax)
            0: smp_x = SW'(val);
            1: smp_y = SW'(val);
            default: smp_z = SW'(val);
        endcase
    endtask

    task automatic tap(input int ax, input int amp, input int len, input bit rd_fall);
        for (int i = 0; i < len; i++) begin
            @(negedge clk) drive(ax, amp);
        end
        @(negedge clk) begin
            drive(ax, 0);
            src_rd = rd_fall;
        end
        @(negedge clk) src_rd = 1'b0;
    endtask

    task automatic rd_clear();
        @(negedge clk) src_rd = 1'b1;
        @(negedge clk) src_rd = 1'b0;
    endtask

    task automatic settle();
        smp_x = '0; smp_y = '0; smp_z = '0;
        repeat (200) @(negedge clk);
        rd_clear();
    endtask

    task automatic t_reset();
        chk("R1 src", tap_src, 7'b0);
        chk("R1 irq", {6'b0, tap_irq}, 7'b0);
    endtask

    task automatic t_single_and_clear();
        settle();
        tap(0, 40, 3, 1'b0);
        chk("R3 x single", tap_src, 7'b1000001);
        chk("R11 irq", {6'b0, tap_irq}, 7'd1);
        rd_clear();
        chk("R10 read clears", tap_src, 7'b0);
    endtask

    task automatic t_threshold();
        settle();
        tap(0, 16, 3, 1'b0);
        chk("R2 equal not above", tap_src, 7'b0);
        tap(1, -40, 3, 1'b0);
        chk("R2 negative y", tap_src, 7'b1000100);
        rd_clear();
        thr_z = 4'd0;
        tap(2, 200, 3, 1'b0);
        chk("R2 zero threshold", tap_src, 7'b0);
        thr_z = 4'd4;
        tap(2, 40, 3, 1'b0);
        chk("R3 z single", tap_src, 7'b1010000);
    endtask

    task automatic t_long_pulse();
        settle();
        tap(0, 40, 60, 1'b0);
        chk("R4 long pulse", tap_src, 7'b0);
        tap(0, 40, 3, 1'b0);
        chk("R4 re-arm", tap_src, 7'b1000001);
    endtask

    task automatic t_single_off();
        settle();
        cfg_single_en = 3'b000;
        cfg_double_en = 3'b001;
        tap(0, 40, 3, 1'b0);
        chk("R5 single disabled", tap_src, 7'b0);
        cfg_single_en = 3'b111;
        cfg_double_en = 3'b000;
    endtask

    task automatic t_double();
        settle();
        cfg_double_en = 3'b001;
        tap(0, 40, 3, 1'b0);
        chk("R3 first tap", tap_src, 7'b1000001);
        rd_clear();
        repeat (33) @(negedge clk);
        tap(0, 40, 3, 1'b0);
        chk("R7 double x", tap_src, 7'b1000010);
        cfg_double_en = 3'b000;
    endtask

    task automatic t_latency_window();
        settle();
        cfg_double_en = 3'b001;
        tap(0, 40, 3, 1'b0);
        rd_clear();
        repeat (4) @(negedge clk);
        tap(0, 40, 3, 1'b0);
        chk("R6 ignored in latency", tap_src, 7'b0);
        repeat (150) @(negedge clk);
        chk("R8 window expired", tap_src, 7'b0);
        tap(0, 40, 3, 1'b0);
        chk("R8 single again", tap_src, 7'b1000001);
        cfg_double_en = 3'b000;
    endtask

    task automatic t_pass_through();
        settle();
        cfg_latch = 1'b0;
        tap(1, 40, 3, 1'b0);
        chk("R9 pulse high", tap_src, 7'b1000100);
        @(negedge clk);
        chk("R9 pulse gone", tap_src, 7'b0);
        chk("R11 irq low", {6'b0, tap_irq}, 7'd0);
        cfg_latch = 1'b1;
    endtask

    task automatic t_collide();
        settle();
        tap(0, 40, 3, 1'b0);
        chk("R10 x held", tap_src, 7'b1000001);
        tap(1, 40, 3, 1'b1);
        chk("R10 set beats clear", tap_src, 7'b1000100);
    endtask

    task automatic t_tick_limit();
        settle();
        time_limit = 8'd0;
        tap(0, 40, 12, 1'b0);
        chk("R12 limit zero expires", tap_src, 7'b0);
        time_limit = 8'd3;
        tap(0, 40, 8, 1'b0);
        chk("R12 limit three fits", tap_src, 7'b1000001);
        time_limit = 8'd6;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_single_and_clear();
        t_threshold();
        t_long_pulse();
        t_single_off();
        t_double();
        t_latency_window();
        t_pass_through();
        t_collide();
        t_tick_limit();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule